// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide parallel flash device and runs the device's pulse-and-verify algorithms for it. A client hands over one request at a time: program a single byte at an address, or erase the whole array. The sequencer then drives the chip-enable, output-enable and write-enable strobes, the address bus and the outgoing data bus. It writes the command bytes the device expects, waits out each pulse, reads the result back and compares it. When the result does not match, it repeats the pulse until a limit is reached.

For a byte program, each attempt writes a setup command, then writes the data, then waits the program pulse time. It then writes a verify command, waits the write-to-read recovery time and reads the byte back. For a chip erase, each attempt writes the erase command twice and waits the erase pulse time. It then verifies bytes one after another, from the first address that has not yet verified up to the last address. If a byte is not yet blank, it issues a fresh erase pulse and resumes verifying at that same address. When the retry limit is used up, the sequencer puts the device back in read mode and reports a failure. Every strobe width and waiting time is a cycle count set by a parameter.

Top module: `flash_pe_seq`

## Requirements
- R1: A request (`req_valid` high) is taken only in a cycle where `req_ready` is high. `req_ready` is low from the cycle after acceptance until the operation ends. A request presented while busy has no effect on the bus traffic or on the result.
- R2: A program request (`req_op` = 0) writes, at the requested address, the byte 40h, then the requested data byte, then C0h. It then reads that address back.
- R3: After the write-enable rising edge of a program data write, at least `T_PGM` cycles pass before the write-enable falling edge of the next write.
- R4: Each read-back drives output-enable and chip-enable low for exactly `T_ACC` cycles and samples the data at the end of that window. The output-enable falling edge comes at least `T_WRV` cycles after the previous write-enable rising edge.
- R5: A program verify passes when the byte read back equals the requested data. The operation then ends with `done` high, `pass` high and `pulse_count` equal to the number of program pulses issued.
- R6: If the byte read back still differs after `MAX_PGM` program pulses, the sequencer writes FFh twice at the target address. It then ends with `pass` low and `pulse_count` equal to `MAX_PGM`.
- R7: An erase request (`req_op` = 1) writes 20h twice. After the second write-enable rising edge, at least `T_ERS` cycles pass before the next write-enable falling edge. Verification starts at address 0, whatever `req_addr` holds.
- R8: Erase verify writes A0h at the current address, then reads it back. A read of FFh moves on to the next address. Any other value triggers another erase pulse (20h, 20h) and resumes at the same address. Erase passes once the last address reads FFh, with `pulse_count` equal to the number of erase pulses.
- R9: If a byte is still not FFh after `MAX_ERS` erase pulses, the sequencer writes FFh twice at the failing address. It then ends with `pass` low and `pulse_count` equal to `MAX_ERS`.
- R10: `done` is high for exactly one cycle per operation, and `pass` is valid in that same cycle. `pass` and `pulse_count` then hold until the next request is accepted.
- R11: Write-enable and output-enable are never low together. Chip-enable is low whenever either of them is low. The outgoing data bus is enabled only while output-enable is high. Each write-enable low pulse lasts exactly `T_WP` cycles.
- R12: While reset is held and straight after it is released, all three strobes are high, the data bus is not driven, `done` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 1 | 0 = program byte, 1 = erase chip |
| req_addr | input | ADDR_W | Byte address for program (ignored for erase) |
| req_data | input | 8 | Byte to program |
| req_ready | output | 1 | Idle, request can be taken |
| done | output | 1 | One-cycle end-of-operation strobe |
| pass | output | 1 | Result of the last operation |
| pulse_count | output | PULSE_W | Pulses issued by the last operation |
| flash_addr | output | ADDR_W | Device address bus |
| flash_dq_out | output | 8 | Device data bus, outgoing |
| flash_dq_oe | output | 1 | Enable for the outgoing data bus |
| flash_dq_in | input | 8 | Device data bus, incoming |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_we_n | output | 1 | Write enable, active low |

## Verification
The bench drives an erase in which bytes blank after different numbers of pulses. A design that restarted the walk at address 0, or skipped past a failing byte, would write A0h at the wrong addresses or report the wrong pulse count. Both retry limits are driven to exhaustion. An off-by-one limit would show up as an extra or missing pulse, or as missing FFh writes. Extra requests are sent while the sequencer is busy; accepting one would inject stray command writes. Every write-enable pulse and every read window is timed, so shortened program, erase or recovery waits, or a read that samples too early, are all reported.

// File: rtl/flash_pe_pkg.sv
// Shared definitions for the flash program/erase sequencer: operation
// encoding, device command bytes and the state encodings of the
// sequencer and of its bus-cycle engine.
package flash_pe_pkg;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } fpe_op_e;

    localparam logic [7:0] CMD_PROG_SETUP   = 8'h40;
    localparam logic [7:0] CMD_PROG_VERIFY  = 8'hC0;
    localparam logic [7:0] CMD_ERASE        = 8'h20;
    localparam logic [7:0] CMD_ERASE_VERIFY = 8'hA0;
    localparam logic [7:0] CMD_RESET        = 8'hFF;
    localparam logic [7:0] BLANK_BYTE       = 8'hFF;

    typedef enum logic [3:0] {
        S_IDLE,
        S_P_SETUP,
        S_P_DATA,
        S_P_WAIT,
        S_P_VCMD,
        S_E_SETUP,
        S_E_CONF,
        S_E_WAIT,
        S_E_VCMD,
        S_RECOV,
        S_READ,
        S_CHECK,
        S_RST1,
        S_RST2
    } fpe_state_e;

    typedef enum logic [2:0] {
        BUS_IDLE,
        BUS_SETUP,
        BUS_PULSE,
        BUS_HOLD,
        BUS_READ
    } fpe_bus_e;

endpackage

// File: rtl/flash_pe_timer.sv
// One-shot delay counter. A load starts a countdown of `len` cycles and
// `fire` pulses for one cycle when it ends.
// Assumes len >= 1 and that no new load arrives while a count is running.
module flash_pe_timer #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         fire
);

    logic [W-1:0] cnt;
    logic         run;

    // Count down after a load and flag expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            run  <= 1'b0;
            fire <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (load) begin
                cnt <= len;
                run <= 1'b1;
            end else if (run) begin
                if (cnt <= W'(1)) begin
                    run  <= 1'b0;
                    fire <= 1'b1;
                end else begin
                    cnt <= cnt - W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/flash_pe_bus.sv
// Bus-cycle engine. It runs one device write cycle (address and data setup,
// write-enable pulse, hold) or one read cycle (output-enable window with a
// sample at its end), then gives a one-cycle done strobe.
// Assumes start comes only while the engine is idle, and every timing
// parameter is >= 1. The address is held stable by the caller.
module flash_pe_bus
    import flash_pe_pkg::*;
#(
    parameter int T_AS  = 2,
    parameter int T_WP  = 4,
    parameter int T_WH  = 2,
    parameter int T_ACC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       rd,
    input  logic [7:0] wr_byte,
    input  logic [7:0] dq_in,
    output logic       done,
    output logic [7:0] rd_byte,
    output logic [7:0] wr_out,
    output logic       ce_n,
    output logic       oe_n,
    output logic       we_n,
    output logic       dq_oe
);

    localparam int M1   = (T_AS > T_WP) ? T_AS : T_WP;
    localparam int M2   = (T_WH > T_ACC) ? T_WH : T_ACC;
    localparam int CMAX = (M1 > M2) ? M1 : M2;
    localparam int CW   = $clog2(CMAX + 1);

    fpe_bus_e      st;
    logic [CW-1:0] cnt;

    // Step through the phases of one bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= BUS_IDLE;
            cnt     <= '0;
            done    <= 1'b0;
            rd_byte <= '0;
            wr_out  <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                BUS_IDLE: begin
                    if (start) begin
                        if (rd) begin
                            st  <= BUS_READ;
                            cnt <= CW'(T_ACC - 1);
                        end else begin
                            st     <= BUS_SETUP;
                            cnt    <= CW'(T_AS - 1);
                            wr_out <= wr_byte;
                        end
                    end
                end
                BUS_SETUP: begin
                    if (cnt == '0) begin
                        st  <= BUS_PULSE;
                        cnt <= CW'(T_WP - 1);
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                BUS_PULSE: begin
                    if (cnt == '0) begin
                        st  <= BUS_HOLD;
                        cnt <= CW'(T_WH - 1);
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                BUS_HOLD: begin
                    if (cnt == '0) begin
                        st   <= BUS_IDLE;
                        done <= 1'b1;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                BUS_READ: begin
                    if (cnt == '0) begin
                        st      <= BUS_IDLE;
                        done    <= 1'b1;
                        rd_byte <= dq_in;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                default: st <= BUS_IDLE;
            endcase
        end
    end

    // Decode the strobes from the phase.
    always_comb begin
        ce_n  = (st == BUS_IDLE);
        we_n  = (st != BUS_PULSE);
        oe_n  = (st != BUS_READ);
        dq_oe = (st == BUS_SETUP) || (st == BUS_PULSE) || (st == BUS_HOLD);
    end

endmodule

// File: rtl/flash_pe_verify.sv
// Target register and comparator. It holds the address in use and the byte
// expected on read-back: the requested data for program, or the blank value
// for erase. For erase it steps the address upward one byte at a time.
// Assumes at most one of the load and advance controls is high per cycle.
module flash_pe_verify
    import flash_pe_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_prog,
    input  logic              load_erase,
    input  logic              advance,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [7:0]        data_in,
    input  logic [7:0]        rd_byte,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [7:0]        want,
    output logic              at_last,
    output logic              match
);

    // Hold or step the working address and the expected byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            want     <= BLANK_BYTE;
        end else if (load_prog) begin
            cur_addr <= addr_in;
            want     <= data_in;
        end else if (load_erase) begin
            cur_addr <= '0;
            want     <= BLANK_BYTE;
        end else if (advance) begin
            cur_addr <= cur_addr + ADDR_W'(1);
        end
    end

    // Compare the read-back and spot the top of the array.
    always_comb begin
        match   = (rd_byte == want);
        at_last = &cur_addr;
    end

endmodule

// File: rtl/flash_pe_seq.sv
// Flash program/erase sequencer top. It takes one request at a time and runs
// the device's pulse/verify/retry algorithm through the bus engine, then
// reports done, pass and the number of pulses used.
// Assumes the programming supply is already switched on and that the flash
// bus belongs to this block for the whole operation.
module flash_pe_seq
    import flash_pe_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int T_AS    = 2,
    parameter int T_WP    = 4,
    parameter int T_WH    = 2,
    parameter int T_ACC   = 4,
    parameter int T_PGM   = 1000,
    parameter int T_ERS   = 1000000,
    parameter int T_WRV   = 600,
    parameter int MAX_PGM = 25,
    parameter int MAX_ERS = 1000,
    parameter int PULSE_W = $clog2(((MAX_ERS > MAX_PGM) ? MAX_ERS : MAX_PGM) + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_op,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [7:0]         req_data,
    output logic               req_ready,
    output logic               done,
    output logic               pass,
    output logic [PULSE_W-1:0] pulse_count,
    output logic [ADDR_W-1:0]  flash_addr,
    output logic [7:0]         flash_dq_out,
    output logic               flash_dq_oe,
    input  logic [7:0]         flash_dq_in,
    output logic               flash_ce_n,
    output logic               flash_oe_n,
    output logic               flash_we_n
);

    localparam int TM1   = (T_PGM > T_ERS) ? T_PGM : T_ERS;
    localparam int TMAX  = (TM1 > T_WRV) ? TM1 : T_WRV;
    localparam int TMR_W = $clog2(TMAX + 1);

    fpe_state_e         st, nxt;
    logic               issued;
    logic               is_erase;
    logic [PULSE_W-1:0] pulses;
    logic               pass_q, done_q;

    logic               bus_start, bus_rd, bus_done;
    logic [7:0]         bus_byte, rd_byte;
    logic               tmr_load, tmr_fire;
    logic [TMR_W-1:0]   tmr_len;
    logic               is_wait, step_ok;
    logic               load_prog, load_erase, advance;
    logic [ADDR_W-1:0]  cur_addr;
    logic [7:0]         want;
    logic               at_last, match;
    logic [PULSE_W-1:0] limit;

    flash_pe_bus #(
        .T_AS (T_AS),
        .T_WP (T_WP),
        .T_WH (T_WH),
        .T_ACC(T_ACC)
    ) u_bus (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (bus_start),
        .rd     (bus_rd),
        .wr_byte(bus_byte),
        .dq_in  (flash_dq_in),
        .done   (bus_done),
        .rd_byte(rd_byte),
        .wr_out (flash_dq_out),
        .ce_n   (flash_ce_n),
        .oe_n   (flash_oe_n),
        .we_n   (flash_we_n),
        .dq_oe  (flash_dq_oe)
    );

    flash_pe_timer #(
        .W(TMR_W)
    ) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .len  (tmr_len),
        .fire (tmr_fire)
    );

    flash_pe_verify #(
        .ADDR_W(ADDR_W)
    ) u_vfy (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_prog (load_prog),
        .load_erase(load_erase),
        .advance   (advance),
        .addr_in   (req_addr),
        .data_in   (req_data),
        .rd_byte   (rd_byte),
        .cur_addr  (cur_addr),
        .want      (want),
        .at_last   (at_last),
        .match     (match)
    );

    // Choose the bus action, the timer length and the follow-on state.
    always_comb begin
        bus_start = 1'b0;
        bus_rd    = 1'b0;
        bus_byte  = CMD_RESET;
        tmr_load  = 1'b0;
        tmr_len   = '0;
        is_wait   = 1'b0;
        nxt       = st;
        case (st)
            S_P_SETUP: begin bus_start = !issued; bus_byte = CMD_PROG_SETUP;   nxt = S_P_DATA;  end
            S_P_DATA:  begin bus_start = !issued; bus_byte = want;             nxt = S_P_WAIT;  end
            S_P_WAIT:  begin is_wait = 1'b1; tmr_load = !issued; tmr_len = TMR_W'(T_PGM); nxt = S_P_VCMD; end
            S_P_VCMD:  begin bus_start = !issued; bus_byte = CMD_PROG_VERIFY;  nxt = S_RECOV;   end
            S_E_SETUP: begin bus_start = !issued; bus_byte = CMD_ERASE;        nxt = S_E_CONF;  end
            S_E_CONF:  begin bus_start = !issued; bus_byte = CMD_ERASE;        nxt = S_E_WAIT;  end
            S_E_WAIT:  begin is_wait = 1'b1; tmr_load = !issued; tmr_len = TMR_W'(T_ERS); nxt = S_E_VCMD; end
            S_E_VCMD:  begin bus_start = !issued; bus_byte = CMD_ERASE_VERIFY; nxt = S_RECOV;   end
            S_RECOV:   begin is_wait = 1'b1; tmr_load = !issued; tmr_len = TMR_W'(T_WRV); nxt = S_READ; end
            S_READ:    begin bus_start = !issued; bus_rd = 1'b1;               nxt = S_CHECK;   end
            S_RST1:    begin bus_start = !issued; bus_byte = CMD_RESET;        nxt = S_RST2;    end
            S_RST2:    begin bus_start = !issued; bus_byte = CMD_RESET;        nxt = S_IDLE;    end
            default:   ;
        endcase
        step_ok = is_wait ? tmr_fire : bus_done;
    end

    // Controls for the target register and the active retry limit.
    always_comb begin
        load_prog  = (st == S_IDLE) && req_valid && (req_op == OP_PROGRAM);
        load_erase = (st == S_IDLE) && req_valid && (req_op == OP_ERASE);
        advance    = (st == S_CHECK) && match && is_erase && !at_last;
        limit      = is_erase ? PULSE_W'(MAX_ERS) : PULSE_W'(MAX_PGM);
    end

    // Main sequencing: accept, step, count pulses and decide after each verify.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            issued   <= 1'b0;
            is_erase <= 1'b0;
            pulses   <= '0;
            pass_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        is_erase <= req_op;
                        pulses   <= '0;
                        pass_q   <= 1'b0;
                        issued   <= 1'b0;
                        st       <= (req_op == OP_ERASE) ? S_E_SETUP : S_P_SETUP;
                    end
                end
                S_CHECK: begin
                    if (match) begin
                        if (!is_erase || at_last) begin
                            st     <= S_IDLE;
                            done_q <= 1'b1;
                            pass_q <= 1'b1;
                        end else begin
                            st <= S_E_VCMD;
                        end
                    end else if (pulses == limit) begin
                        st <= S_RST1;
                    end else begin
                        st <= is_erase ? S_E_SETUP : S_P_SETUP;
                    end
                end
                default: begin
                    if (step_ok) begin
                        issued <= 1'b0;
                        st     <= nxt;
                        if ((st == S_P_DATA) || (st == S_E_CONF)) begin
                            pulses <= pulses + PULSE_W'(1);
                        end
                        if (st == S_RST2) begin
                            done_q <= 1'b1;
                        end
                    end else begin
                        issued <= 1'b1;
                    end
                end
            endcase
        end
    end

    // Drive the request-side outputs and the address bus.
    always_comb begin
        req_ready   = (st == S_IDLE);
        done        = done_q;
        pass        = pass_q;
        pulse_count = pulses;
        flash_addr  = cur_addr;
    end

endmodule

// File: rtl/flash_pe_seq_chk.sv
// Property checker for the flash program/erase sequencer, bound to every
// instance of the top. It watches the device strobes and the request-side
// handshake only.
module flash_pe_seq_chk #(
    parameter int PULSE_W    = 10,
    parameter int MAX_PULSES = 1000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               done,
    input logic [PULSE_W-1:0] pulse_count,
    input logic               flash_ce_n,
    input logic               flash_oe_n,
    input logic               flash_we_n,
    input logic               flash_dq_oe
);

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!flash_we_n && !flash_oe_n));

    // R11
    ce_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_we_n || !flash_oe_n) |-> !flash_ce_n);

    // R11
    dq_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flash_dq_oe |-> flash_oe_n);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    // R10
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> $stable(pulse_count));

    // R6
    pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_count <= PULSE_W'(MAX_PULSES));

endmodule

bind flash_pe_seq flash_pe_seq_chk #(
    .PULSE_W   (PULSE_W),
    .MAX_PULSES((MAX_ERS > MAX_PGM) ? MAX_ERS : MAX_PGM)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .done       (done),
    .pulse_count(pulse_count),
    .flash_ce_n (flash_ce_n),
    .flash_oe_n (flash_oe_n),
    .flash_we_n (flash_we_n),
    .flash_dq_oe(flash_dq_oe)
);

// File: tb/flash_pe_seq_test.sv
// Bench: a behavioural flash device with per-byte pulse needs, a queue of
// expected command writes built from the requirements, and per-clock
// timing and strobe checks.
module flash_pe_seq_test;

    localparam int ADDR_W  = 3;
    localparam int NB      = 1 << ADDR_W;
    localparam int T_AS    = 2;
    localparam int T_WP    = 3;
    localparam int T_WH    = 2;
    localparam int T_ACC   = 4;
    localparam int T_PGM   = 20;
    localparam int T_ERS   = 40;
    localparam int T_WRV   = 6;
    localparam int MAX_PGM = 4;
    localparam int MAX_ERS = 5;
    localparam int PULSE_W = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_op = 1'b0;
    logic [ADDR_W-1:0]  req_addr = '0;
    logic [7:0]         req_data = '0;
    logic               req_ready, done, pass;
    logic [PULSE_W-1:0] pulse_count;
    logic [ADDR_W-1:0]  flash_addr;
    logic [7:0]         flash_dq_out, flash_dq_in;
    logic               flash_dq_oe, flash_ce_n, flash_oe_n, flash_we_n;

    always #5 clk = ~clk;

    flash_pe_seq #(
        .ADDR_W(ADDR_W), .T_AS(T_AS), .T_WP(T_WP), .T_WH(T_WH), .T_ACC(T_ACC),
        .T_PGM(T_PGM), .T_ERS(T_ERS), .T_WRV(T_WRV),
        .MAX_PGM(MAX_PGM), .MAX_ERS(MAX_ERS), .PULSE_W(PULSE_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_ready(req_ready),
        .done(done), .pass(pass), .pulse_count(pulse_count),
        .flash_addr(flash_addr), .flash_dq_out(flash_dq_out),
        .flash_dq_oe(flash_dq_oe), .flash_dq_in(flash_dq_in),
        .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    // Behavioural device
    logic [7:0] mem [NB];
    int pgm_need [NB];
    int pgm_hits [NB];
    int ers_need [NB];
    int ers_hits = 0;
    bit prog_armed = 0;
    bit ers_armed = 0;

    assign flash_dq_in = (!flash_ce_n && !flash_oe_n) ? mem[flash_addr] : 8'h00;

    // Reference expectations
    logic [ADDR_W+7:0] exp_q [$];
    bit    exp_pass;
    int    exp_cnt;
    string wr_tag = "R2";
    string end_tag = "R5";
    bit    done_seen = 0;

    // Timing trackers
    bit prev_we = 1, prev_oe = 1;
    int we_fall = 0, we_rise = -1000, oe_fall = 0;
    int gap_kind = 0, gap_start = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Per-cycle monitor and device model, away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            // R11 strobe rules every cycle
            check(!(!flash_we_n && !flash_oe_n) &&
                  ((flash_we_n && flash_oe_n) || !flash_ce_n) &&
                  (!flash_dq_oe || flash_oe_n),
                  "R11", "strobe rule", {flash_ce_n, flash_oe_n, flash_we_n}, 0);

            if (prev_we && !flash_we_n) begin
                we_fall = cyc;
                if (gap_kind == 1)
                    check(cyc - gap_start >= T_PGM, "R3", "program pulse wait", cyc - gap_start, T_PGM);
                if (gap_kind == 2)
                    check(cyc - gap_start >= T_ERS, "R7", "erase pulse wait", cyc - gap_start, T_ERS);
                gap_kind = 0;
            end

            if (!prev_we && flash_we_n) begin
                logic [ADDR_W+7:0] got;
                logic [ADDR_W+7:0] e;
                int a;
                got = {flash_addr, flash_dq_out};
                we_rise = cyc;
                check(cyc - we_fall == T_WP, "R11", "write pulse width", cyc - we_fall, T_WP);
                if (exp_q.size() == 0) begin
                    check(0, wr_tag, "unexpected write", got, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(got == e, wr_tag, "write addr/data", got, e);
                end
                a = int'(flash_addr);
                gap_start = cyc;
                if (prog_armed) begin
                    gap_kind = 1;
                    prog_armed = 0;
                    pgm_hits[a]++;
                    if (pgm_hits[a] >= pgm_need[a]) mem[a] = mem[a] & flash_dq_out;
                end else if (flash_dq_out == 8'h40) begin
                    prog_armed = 1;
                    ers_armed = 0;
                end else if (flash_dq_out == 8'h20) begin
                    if (ers_armed) begin
                        gap_kind = 2;
                        ers_armed = 0;
                        ers_hits++;
                        for (int k = 0; k < NB; k++)
                            if (ers_hits >= ers_need[k]) mem[k] = 8'hFF;
                    end else begin
                        ers_armed = 1;
                    end
                end else begin
                    ers_armed = 0;
                end
            end

            if (prev_oe && !flash_oe_n) begin
                oe_fall = cyc;
                check(cyc - we_rise >= T_WRV, "R4", "recovery before read", cyc - we_rise, T_WRV);
            end
            if (!prev_oe && flash_oe_n)
                check(cyc - oe_fall == T_ACC, "R4", "read window", cyc - oe_fall, T_ACC);

            if (done) begin
                check(pass == exp_pass, end_tag, "pass", pass, exp_pass);
                check(int'(pulse_count) == exp_cnt, end_tag, "pulse count", pulse_count, exp_cnt);
                check(exp_q.size() == 0, end_tag, "writes left over", exp_q.size(), 0);
                check(req_ready, "R10", "ready with done", req_ready, 1);
                done_seen = 1;
            end
        end
        prev_we = flash_we_n;
        prev_oe = flash_oe_n;
    end

    task automatic push_wr(input int a, input logic [7:0] d);
        exp_q.push_back({ADDR_W'(a), d});
    endtask

    // Expected traffic for a program request.
    task automatic plan_program(input int a, input logic [7:0] d, input int need);
        int n;
        n = (need > MAX_PGM) ? MAX_PGM : need;
        for (int i = 0; i < n; i++) begin
            push_wr(a, 8'h40); push_wr(a, d); push_wr(a, 8'hC0);
        end
        if (need > MAX_PGM) begin
            push_wr(a, 8'hFF); push_wr(a, 8'hFF);
        end
        exp_pass = (need <= MAX_PGM);
        exp_cnt = n;
    endtask

    // Expected traffic for an erase request, from the per-byte needs.
    task automatic plan_erase();
        int p, np;
        p = 0; np = 0;
        forever begin
            push_wr(p, 8'h20); push_wr(p, 8'h20);
            np++;
            while (p < NB) begin
                push_wr(p, 8'hA0);
                if (np >= ers_need[p]) p++;
                else break;
            end
            if (p >= NB) begin exp_pass = 1; break; end
            if (np == MAX_ERS) begin
                push_wr(p, 8'hFF); push_wr(p, 8'hFF);
                exp_pass = 0; break;
            end
        end
        exp_cnt = np;
    endtask

    // Issue one request, optionally poke while busy, and wait for the end.
    task automatic run_op(input bit op, input int a, input logic [7:0] d, input bit poke);
        int w;
        done_seen = 0;
        @(negedge clk);
        req_valid = 1; req_op = op; req_addr = ADDR_W'(a); req_data = d;
        @(negedge clk);
        req_valid = 0;
        if (poke) begin
            repeat (10) @(negedge clk);
            check(!req_ready, "R1", "ready while busy", req_ready, 0);
            req_valid = 1; req_op = ~op; req_addr = ADDR_W'(a + 1); req_data = 8'h5A;
            repeat (4) @(negedge clk);
            req_valid = 0;
        end
        w = 0;
        while (!done_seen && w < 20000) begin
            @(negedge clk);
            w++;
        end
        if (!done_seen) check(0, end_tag, "watchdog expired", w, 0);
        @(negedge clk);
        check(!done, "R10", "done one cycle", done, 0);
        check(pass == exp_pass && int'(pulse_count) == exp_cnt, "R10", "result held",
              {pass, pulse_count}, {exp_pass, exp_cnt[PULSE_W-1:0]});
    endtask

    task automatic clear_hits();
        for (int k = 0; k < NB; k++) pgm_hits[k] = 0;
        ers_hits = 0;
        prog_armed = 0;
        ers_armed = 0;
    endtask

    initial begin
        for (int k = 0; k < NB; k++) begin
            mem[k] = 8'hFF; pgm_need[k] = 1; pgm_hits[k] = 0; ers_need[k] = 1;
        end
        repeat (3) @(negedge clk);
        // R12 while in reset
        check(flash_ce_n && flash_oe_n && flash_we_n && !flash_dq_oe && !done && req_ready,
              "R12", "reset state", {flash_ce_n, flash_oe_n, flash_we_n, flash_dq_oe, done, req_ready}, 6'b111001);
        rst_n = 1;
        @(negedge clk);
        check(flash_ce_n && flash_oe_n && flash_we_n && !done && req_ready,
              "R12", "after reset", {flash_ce_n, flash_oe_n, flash_we_n, done, req_ready}, 5'b11101);

        // R2 R5: program, first pulse verifies
        clear_hits(); wr_tag = "R2"; end_tag = "R5";
        pgm_need[5] = 1; plan_program(5, 8'hA5, 1);
        run_op(1'b0, 5, 8'hA5, 1'b0);

        // R5 R1: program needing three pulses, with requests poked while busy
        clear_hits(); wr_tag = "R1"; end_tag = "R5";
        pgm_need[2] = 3; plan_program(2, 8'h3C, 3);
        run_op(1'b0, 2, 8'h3C, 1'b1);

        // R6: program never verifies
        clear_hits(); wr_tag = "R6"; end_tag = "R6";
        pgm_need[7] = 10; plan_program(7, 8'h00, 10);
        run_op(1'b0, 7, 8'h00, 1'b0);

        // R7 R8: erase with staggered blanking, request address ignored
        clear_hits(); wr_tag = "R7"; end_tag = "R8";
        for (int k = 0; k < NB; k++) mem[k] = 8'h00;
        ers_need[0] = 1; ers_need[1] = 1; ers_need[2] = 3; ers_need[3] = 1;
        ers_need[4] = 2; ers_need[5] = 1; ers_need[6] = 1; ers_need[7] = 4;
        plan_erase();
        run_op(1'b1, 6, 8'h00, 1'b0);

        // R9: erase where one byte never blanks in time
        clear_hits(); wr_tag = "R9"; end_tag = "R9";
        for (int k = 0; k < NB; k++) begin mem[k] = 8'h00; ers_need[k] = 1; end
        ers_need[1] = 2; ers_need[4] = 9;
        plan_erase();
        run_op(1'b1, 0, 8'h00, 1'b0);

        // R5: program after a failed erase, count restarts
        clear_hits(); wr_tag = "R2"; end_tag = "R5";
        mem[0] = 8'hFF; pgm_need[0] = 2; plan_program(0, 8'h81, 2);
        run_op(1'b0, 0, 8'h81, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Global watchdog
    initial begin
        #1500000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual %0d expected done", cyc);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule